// File: doc/BRIEF.md
# Polyphase Subband Matrixing Filter

This block performs the second half of an audio analysis filterbank. A windowing stage writes 512 windowed 40-bit samples into a synchronous RAM. After that, a single start pulse makes this block read the whole block once. It folds the samples into 64 partial sums, which it keeps in an internal register file. It then multiplies that 64-entry vector by a fixed 32x64 cosine matrix. The result is 32 subband samples, streamed out in ascending order. Each sample carries a valid strobe and its subband index.

The block is run once per fresh block of windowed samples. For each channel that is 36 runs per frame, in three groups of twelve. A single multiply-accumulate unit serves every output. The cosine matrix is not stored as 2048 entries. It is regenerated from a 128-entry cosine table, addressed by the phase (2i+1)(k-16) mod 128.

Top module: `sbm_top`

## Requirements
- R1: Partial sums are Y[i] = sum of Z[i + 64*j] over j = 0..7, for i = 0..63, computed at full precision with no loss of bits.
- R2: The matrix entry for output i and partial sum k is round(cos((2i+1)(k-16)*pi/64) * 16384), held as a signed 16-bit Q1.14 value.
- R3: The output is S[i] = floor((sum over k of Y[k]*M[i][k] + 8192) / 16384), so exact halves round toward plus infinity. It is clamped to the signed 24-bit range [-8388608, 8388607].
- R4: Every run emits exactly 32 one-cycle valid strobes, with indices 0, 1, ..., 31 in that order.
- R5: The RAM read address in the n-th cycle after the start is taken (n = 0..511) is (n mod 8)*64 + n/8. The tap number j is therefore the high three address bits and the partial-sum index i the low six bits. Each address is issued exactly once. Read data is used one cycle after its address.
- R6: Output S[i] is valid 577 + 64*i cycles after the clock edge that takes the start.
- R7: A one-cycle done pulse follows in the cycle right after the valid of S[31].
- R8: A start pulse that arrives while a run is in progress is ignored. The address sequence, output timing and values of the run continue unchanged.
- R9: A synchronous active-low reset returns the block to idle and drops valid and done on the next edge. It clears the partial-sum file and the accumulator. A start after the reset performs a complete, correct run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| zr_addr | output | 9 | Read address to the windowed-sample RAM |
| zr_data | input | 40 | Read data, valid one cycle after the address |
| sb_valid | output | 1 | Subband output strobe |
| sb_index | output | 5 | Subband index of the current output |
| sb_data | output | 24 | Rounded, saturated subband sample |
| done | output | 1 | One-cycle pulse after the last subband output |

## Verification
The assertions rely on three properties of the inputs. The RAM behind zr_addr returns the addressed word exactly one cycle later. Its contents stay fixed from the start pulse until done. Start is a single-cycle pulse. The stimulus reloads the RAM model only between runs and drives start for exactly one cycle. It deliberately injects extra start pulses during the fold and matrix phases, and one reset in the middle of a run. The data patterns are chosen to hit both saturation limits and the rounding of small values, in addition to ramps and random words.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FOLD = 2'd1,
      ST_MAC  = 2'd2
   } sbm_state_e;

endpackage

// File: rtl/sbm_cos_rom.sv
module sbm_cos_rom #(
   parameter int NOUT  = 32,
   parameter int CW    = 16,
   parameter int CFRAC = 14,
   localparam int NPH  = 4 * NOUT,
   localparam int PHW  = $clog2(NPH)
) (
   input  logic [PHW-1:0]        phase,
   output logic signed [CW-1:0]  coef
);

   logic signed [CW-1:0] tab [NPH];

   // one full cosine period, cos(g*pi/(2*NOUT)), quantised at elaboration
   for (genvar g = 0; g < NPH; g++) begin : g_tab
      localparam real ANG = 3.14159265358979323846 * real'(g) / real'(2 * NOUT);
      localparam real SCL = $cos(ANG) * real'(1 << CFRAC);
      localparam int  QV  = $rtoi($floor(SCL + 0.5));
      assign tab[g] = CW'(QV);
   end

   assign coef = tab[phase];

endmodule

// File: rtl/sbm_fold.sv
module sbm_fold #(
   parameter int ZW   = 40,
   parameter int NY   = 64,
   parameter int TAPS = 8,
   localparam int YW  = ZW + $clog2(TAPS),
   localparam int IW  = $clog2(NY),
   localparam int TW  = $clog2(TAPS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [TW-1:0]         in_tap,
   input  logic [IW-1:0]         in_col,
   input  logic signed [ZW-1:0]  in_data,
   input  logic [IW-1:0]         rd_idx,
   output logic signed [YW-1:0]  rd_y
);

   logic signed [YW-1:0] run_sum;
   logic signed [YW-1:0] y_rf [NY];
   logic signed [YW-1:0] nxt_sum;

   assign nxt_sum = ((in_tap == '0) ? '0 : run_sum) + YW'(in_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_sum <= '0;
         for (int n = 0; n < NY; n++) y_rf[n] <= '0;
      end else if (in_vld) begin
         run_sum <= nxt_sum;
         if (in_tap == TW'(TAPS - 1)) y_rf[in_col] <= nxt_sum;
      end
   end

   assign rd_y = y_rf[rd_idx];

endmodule

// File: rtl/sbm_mac.sv
module sbm_mac #(
   parameter int YW    = 43,
   parameter int CW    = 16,
   parameter int CFRAC = 14,
   parameter int NY    = 64,
   parameter int OW    = 24,
   parameter int XW    = 5,
   localparam int PW   = YW + CW,
   localparam int AW   = PW + $clog2(NY) + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic                  first,
   input  logic                  last,
   input  logic [XW-1:0]         row,
   input  logic signed [YW-1:0]  y_in,
   input  logic signed [CW-1:0]  c_in,
   output logic                  o_vld,
   output logic [XW-1:0]         o_idx,
   output logic signed [OW-1:0]  o_data
);

   localparam logic signed [AW-1:0] OMAX = AW'((64'sd1 <<< (OW - 1)) - 1);
   localparam logic signed [AW-1:0] OMIN = -AW'(64'sd1 <<< (OW - 1));
   localparam logic signed [AW-1:0] HALF = AW'(64'sd1 <<< (CFRAC - 1));

   logic signed [AW-1:0] acc, sum, shf;
   logic signed [PW-1:0] prod;
   logic signed [OW-1:0] clamped;

   assign prod = y_in * c_in;
   assign sum  = (first ? '0 : acc) + AW'(prod);
   assign shf  = (sum + HALF) >>> CFRAC;

   always_comb begin
      if (shf > OMAX)      clamped = OMAX[OW-1:0];
      else if (shf < OMIN) clamped = OMIN[OW-1:0];
      else                 clamped = shf[OW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc    <= '0;
         o_vld  <= 1'b0;
         o_idx  <= '0;
         o_data <= '0;
      end else begin
         o_vld <= en && last;
         if (en) acc <= sum;
         if (en && last) begin
            o_idx  <= row;
            o_data <= clamped;
         end
      end
   end

endmodule

// File: rtl/sbm_top.sv
module sbm_top #(
   parameter int ZW    = 40,
   parameter int NIN   = 512,
   parameter int NOUT  = 32,
   parameter int CW    = 16,
   parameter int CFRAC = 14,
   parameter int OW    = 24,
   localparam int NY   = 2 * NOUT,
   localparam int TAPS = NIN / NY,
   localparam int ADW  = $clog2(NIN),
   localparam int IW   = $clog2(NY),
   localparam int TW   = $clog2(TAPS),
   localparam int XW   = $clog2(NOUT),
   localparam int PHW  = $clog2(4 * NOUT),
   localparam int YW   = ZW + TW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   output logic [ADW-1:0]        zr_addr,
   input  logic signed [ZW-1:0]  zr_data,
   output logic                  sb_valid,
   output logic [XW-1:0]         sb_index,
   output logic signed [OW-1:0]  sb_data,
   output logic                  done
);
   import sbm_pkg::*;

   if (NIN % NY != 0 || (1 << ADW) != NIN || (1 << XW) != NOUT || TAPS < 2)
      $error("sbm_top: NIN must be a power-of-two multiple of 2*NOUT");
   if (CFRAC < 1 || CFRAC > CW - 2)
      $error("sbm_top: CFRAC must leave a sign and an integer bit in CW");

   sbm_state_e           state;
   logic [ADW:0]         rd_cnt;
   logic                 p_vld;
   logic [TW-1:0]        p_tap;
   logic [IW-1:0]        p_col;
   logic [XW-1:0]        mac_r;
   logic [IW-1:0]        mac_k;
   logic signed [YW-1:0] y_rd;
   logic signed [CW-1:0] coef;
   logic [PHW-1:0]       phase;
   logic [2*PHW-1:0]     ph_full;
   logic                 fold_end, mac_en;

   // tap in the high bits, partial-sum column in the low bits
   assign zr_addr  = {rd_cnt[TW-1:0], rd_cnt[ADW-1:TW]};
   assign fold_end = p_vld && (p_col == IW'(NY - 1)) && (p_tap == TW'(TAPS - 1));
   assign mac_en   = (state == ST_MAC);
   assign ph_full  = (2*PHW)'({mac_r, 1'b1}) * (2*PHW)'(PHW'(mac_k) - PHW'(NOUT / 2));
   assign phase    = ph_full[PHW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         rd_cnt <= '0;
         p_vld  <= 1'b0;
         p_tap  <= '0;
         p_col  <= '0;
         mac_r  <= '0;
         mac_k  <= '0;
         done   <= 1'b0;
      end else begin
         done  <= sb_valid && (sb_index == XW'(NOUT - 1));
         p_vld <= (state == ST_FOLD) && !rd_cnt[ADW];
         p_tap <= rd_cnt[TW-1:0];
         p_col <= rd_cnt[ADW-1:TW];
         case (state)
            ST_IDLE: if (start) begin
               state  <= ST_FOLD;
               rd_cnt <= '0;
            end
            ST_FOLD: begin
               if (!rd_cnt[ADW]) rd_cnt <= rd_cnt + 1'b1;
               if (fold_end) begin
                  state <= ST_MAC;
                  mac_r <= '0;
                  mac_k <= '0;
               end
            end
            ST_MAC: begin
               mac_k <= mac_k + 1'b1;
               if (mac_k == IW'(NY - 1)) begin
                  mac_r <= mac_r + 1'b1;
                  if (mac_r == XW'(NOUT - 1)) state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   sbm_fold #(.ZW(ZW), .NY(NY), .TAPS(TAPS)) fold_i (
      .clk(clk), .rst_n(rst_n), .in_vld(p_vld), .in_tap(p_tap), .in_col(p_col),
      .in_data(zr_data), .rd_idx(mac_k), .rd_y(y_rd)
   );

   sbm_cos_rom #(.NOUT(NOUT), .CW(CW), .CFRAC(CFRAC)) rom_i (
      .phase(phase), .coef(coef)
   );

   sbm_mac #(.YW(YW), .CW(CW), .CFRAC(CFRAC), .NY(NY), .OW(OW), .XW(XW)) mac_i (
      .clk(clk), .rst_n(rst_n), .en(mac_en), .first(mac_k == '0),
      .last(mac_k == IW'(NY - 1)), .row(mac_r), .y_in(y_rd), .c_in(coef),
      .o_vld(sb_valid), .o_idx(sb_index), .o_data(sb_data)
   );

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
   parameter int NOUT = 32,
   parameter int ADW  = 9,
   localparam int XW  = $clog2(NOUT)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input sbm_pkg::sbm_state_e state,
   input logic [ADW-1:0]      zr_addr,
   input logic                sb_valid,
   input logic [XW-1:0]       sb_index,
   input logic                done
);
   import sbm_pkg::*;

   logic [XW-1:0] exp_idx;

   always_ff @(posedge clk) begin
      if (!rst_n)        exp_idx <= '0;
      else if (sb_valid) exp_idx <= exp_idx + 1'b1;
   end

   AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      sb_valid |-> sb_index == exp_idx);                                   // R4
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sb_valid |=> !sb_valid);                                             // R6
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(sb_valid) && $past(sb_index) == XW'(NOUT - 1)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                     // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == ST_MAC) |=> state != ST_FOLD);                    // R8
   AST_FOLD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FOLD && $past(state) == ST_FOLD && zr_addr[ADW-4:0] == $past(zr_addr[ADW-4:0])
       && zr_addr[ADW-1:ADW-3] != 3'd0) |-> zr_addr[ADW-1:ADW-3] == $past(zr_addr[ADW-1:ADW-3]) + 3'd1); // R5
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !sb_valid && !done);                                      // R9

endmodule

bind sbm_top sbm_checker #(.NOUT(NOUT), .ADW(ADW)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .state(state), .zr_addr(zr_addr),
   .sb_valid(sb_valid), .sb_index(sb_index), .done(done)
);

// File: tb/sbm_top_tb_top.sv
`timescale 1ns / 1ps
module sbm_top_tb_top;

   localparam int T_FIRST = 577;
   localparam int T_DONE  = 577 + 64 * 31 + 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [8:0]         zr_addr;
   logic signed [39:0] zr_data;
   logic               sb_valid;
   logic [4:0]         sb_index;
   logic signed [23:0] sb_data;
   logic               done;

   logic signed [39:0] mem [512];
   logic signed [23:0] exp_s [32];
   int total = 0, bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sbm_top dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .zr_addr(zr_addr), .zr_data(zr_data),
      .sb_valid(sb_valid), .sb_index(sb_index), .sb_data(sb_data), .done(done)
   );

   // RAM model: one cycle read latency
   always @(posedge clk) zr_data <= mem[zr_addr];

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference: fold, cosine matrix, round half up, clamp (R1, R2, R3)
   task automatic compute_expected();
      logic signed [79:0] y [64];
      for (int i = 0; i < 64; i++) begin
         y[i] = 0;
         for (int j = 0; j < 8; j++) y[i] += 80'(mem[i + 64 * j]);
      end
      for (int r = 0; r < 32; r++) begin
         logic signed [79:0] acc, q;
         acc = 0;
         for (int k = 0; k < 64; k++) begin
            real a;
            longint c;
            a = 3.14159265358979323846 * real'((2 * r + 1) * (k - 16)) / 64.0;
            c = $rtoi($floor($cos(a) * 16384.0 + 0.5));
            acc += y[k] * 80'(c);
         end
         q = (acc + 80'sd8192) >>> 14;
         if (q > 80'sd8388607)       exp_s[r] = 24'sh7fffff;
         else if (q < -80'sd8388608) exp_s[r] = 24'sh800000;
         else                        exp_s[r] = q[23:0];
      end
   endtask

   // one run, compared against the reference every cycle (R4..R8);
   // extra start pulses at t = stray1 / stray2, reset at t = abort (-1: none)
   task automatic run(input int stray1, input int stray2, input int abort);
      compute_expected();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int t = 0; t <= T_DONE + 3; t++) begin
         bit ev;
         int r;
         if (t == abort) begin
            rst_n = 1'b0;
            @(negedge clk);
            chk("R9 valid low after reset", sb_valid, 0);
            chk("R9 done low after reset", done, 0);
            rst_n = 1'b1;
            @(negedge clk);
            return;
         end
         if (t < 512) chk("R5 read address", zr_addr, (t % 8) * 64 + t / 8);
         ev = (t >= T_FIRST) && ((t - T_FIRST) % 64 == 0) && (t < T_DONE);
         r  = (t - T_FIRST) / 64;
         chk("R6 valid timing", sb_valid, ev);
         if (ev && sb_valid) begin
            chk("R4 index order", sb_index, r);
            chk("R3 subband value", sb_data, exp_s[r]);
         end
         chk("R7 done pulse", done, t == T_DONE);
         start = (t == stray1 || t == stray2);
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   initial begin
      for (int n = 0; n < 512; n++) mem[n] = '0;
      repeat (3) @(negedge clk);
      chk("R9 reset valid", sb_valid, 0);
      chk("R9 reset done", done, 0);
      rst_n = 1'b1;
      // R1 R2: ramp pattern, distinct value per address
      for (int n = 0; n < 512; n++) mem[n] = 40'(n * 37 - 9000);
      run(-1, -1, -1);
      // R3: small random values, rounding matters
      for (int n = 0; n < 512; n++) mem[n] = 40'($signed($urandom_range(0, 8191)) - 4096);
      run(-1, -1, -1);
      // R3: positive saturation
      for (int n = 0; n < 512; n++) mem[n] = 40'sh7f_ffff_ffff;
      run(-1, -1, -1);
      // R3: negative saturation
      for (int n = 0; n < 512; n++) mem[n] = 40'sh80_0000_0000;
      run(-1, -1, -1);
      // R8: stray starts during fold and matrix phases, wide random data
      for (int n = 0; n < 512; n++) mem[n] = {8'($urandom), $urandom};
      run(100, 1500, -1);
      // R9: reset in mid run, then a full run
      run(-1, -1, 900);
      for (int n = 0; n < 512; n++) mem[n] = 40'((n % 64 == 5) ? 1000000 : -(n % 13) * 777);
      run(-1, -1, -1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule